// File: doc/BRIEF.md
# Sensor Status Report Serializer

This block turns a snapshot of the board's sensor readings into the payload of a status report, one byte per beat, on a valid/ready stream that marks its final byte with a last flag. A report is requested either by a query pulse or by a pulse signalling that a reset sequence has finished. In the cycle a report starts, the block copies the board location byte, a 10-bit temperature sample and eight 12-bit ADC samples into a holding register. It then sends the report from that copy alone.

Each report starts with the location byte and the report type code. The temperature and the ADC channels follow as two-byte big-endian words, with their unused upper bits set to zero. Zero bytes are appended until the payload reaches the padded length. The next stage adds the link header in front of the payload and appends the checksum.

A request that arrives while a report is still being sent is remembered. A second report follows directly after the last byte of the current one. Any number of requests received during one report produce only one follow-on report.

Top module: `status_frame_builder`

## Requirements
- R1: After reset `out_valid_o` is low, and it stays low until a request pulse arrives.
- R2: A pulse on `query_i` or on `reset_done_i` while idle makes `out_valid_o` high on the next cycle, with payload byte 0 on `out_data_o`.
- R3: Payload byte 0 is the location byte and payload byte 1 is the type code 0x53.
- R4: Payload bytes 2 and 3 carry the 10-bit temperature. Byte 2 is six zero bits followed by temperature bits 9:8. Byte 3 is temperature bits 7:0.
- R5: Payload bytes 4 to 19 carry ADC channels 0 to 7 in rising channel order, two bytes per channel. Channel k uses byte 4+2k, which is four zero bits followed by sample bits 11:8, and byte 5+2k, which is sample bits 7:0.
- R6: Payload bytes 20 to 46 are zero. A report is exactly 47 beats long. `out_last_o` is high on beat 46 and on no other beat.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` and `out_last_o` do not change. The byte index advances only when valid and ready are both high at a clock edge.
- R8: A report carries the input values sampled in the cycle it started. Input changes during the report have no effect on it.
- R9: Any number of request pulses during a report, including one in the cycle the last byte is accepted, produce exactly one follow-on report. That report starts on the next cycle with no idle gap and carries the inputs sampled in the cycle the last byte was accepted.
- R10: If no request is pending when the last byte is accepted, `out_valid_o` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| query_i | input | 1 | Status query request pulse |
| reset_done_i | input | 1 | Reset-sequence-finished request pulse |
| loc_i | input | 8 | Board location byte |
| temp_i | input | 10 | Temperature sample |
| adc_i | input | 96 | ADC samples; channel k in bits 12k+11:12k |
| out_data_o | output | 8 | Payload byte |
| out_valid_o | output | 1 | Byte valid |
| out_last_o | output | 1 | Final payload byte |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The bench holds back ready at random and changes every sensor input at random while reports are in flight. A design that advanced on a stalled beat, or that read live inputs instead of the snapshot, would show bytes that differ from the captured values. All-ones samples show whether the upper bits of each word are zeroed, and a wrong channel order or nibble split shows up as a mismatch at a known byte position. Bursts of requests during a report, and one request placed exactly on the final accepted byte, test the follow-on logic. A design that dropped the request, inserted an idle cycle, or sent one report per pulse would produce the wrong report count or a valid level that differs from the expected one.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
package sfb_pkg;
  typedef logic [7:0] octet_t;

  localparam octet_t STATUS_TYPE = 8'h53;

  // Most significant octet of a word that was zero-extended to 16 bits.
  function automatic octet_t upper_octet(input logic [15:0] w);
    return w[15:8];
  endfunction

  // Least significant octet of a word that was zero-extended to 16 bits.
  function automatic octet_t lower_octet(input logic [15:0] w);
    return w[7:0];
  endfunction
endpackage

// File: rtl/sfb_hold.sv
`timescale 1ns/1ps
module sfb_hold #(
  parameter int N_CH   = 8,
  parameter int CH_W   = 12,
  parameter int TEMP_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [7:0]             loc_i,
  input  logic [TEMP_W-1:0]      temp_i,
  input  logic [N_CH*CH_W-1:0]   adc_i,
  output logic [7:0]             loc_o,
  output logic [TEMP_W-1:0]      temp_o,
  output logic [CH_W-1:0]        adc_o [N_CH]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_o  <= '0;
      temp_o <= '0;
    end else if (load_i) begin
      loc_o  <= loc_i;
      temp_o <= temp_i;
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)      adc_o[k] <= '0;
      else if (load_i) adc_o[k] <= adc_i[k*CH_W +: CH_W];
    end
  end
endmodule

// File: rtl/sfb_byte_sel.sv
`timescale 1ns/1ps
module sfb_byte_sel
  import sfb_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CH_W   = 12,
  parameter int TEMP_W = 10,
  parameter int IDX_W  = 6
) (
  input  logic [7:0]        loc_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [CH_W-1:0]   adc_i [N_CH],
  input  logic [IDX_W-1:0]  idx_i,
  output octet_t            byte_o
);
  localparam int PAYLOAD_LEN = 4 + 2 * N_CH;

  octet_t pl [PAYLOAD_LEN];

  assign pl[0] = loc_i;
  assign pl[1] = STATUS_TYPE;
  assign pl[2] = upper_octet(16'(temp_i));
  assign pl[3] = lower_octet(16'(temp_i));

  for (genvar k = 0; k < N_CH; k++) begin : g_word
    assign pl[4 + 2*k] = upper_octet(16'(adc_i[k]));
    assign pl[5 + 2*k] = lower_octet(16'(adc_i[k]));
  end

  // Every index beyond the meaningful payload selects a zero pad byte.
  always_comb begin
    byte_o = '0;
    for (int i = 0; i < PAYLOAD_LEN; i++) begin
      if (idx_i == IDX_W'(i)) byte_o = pl[i];
    end
  end
endmodule

// File: rtl/sfb_sequencer.sv
`timescale 1ns/1ps
module sfb_sequencer #(
  parameter int PAD_LEN = 47,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(PAD_LEN - 1);

  logic             active_q, pend_q;
  logic [IDX_W-1:0] idx_q;

  // Named events that the assertions refer to.
  logic hs, at_end, hs_last, start_ev, restart_ev;
  assign hs         = active_q & ready_i;
  assign at_end     = (idx_q == END_IDX);
  assign hs_last    = hs & at_end;
  assign start_ev   = ~active_q & trig_i;
  assign restart_ev = hs_last & (pend_q | trig_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (start_ev) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (hs) begin
        if (at_end) begin
          idx_q    <= '0;
          active_q <= restart_ev;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      pend_q <= active_q & ~hs_last & (pend_q | trig_i);
    end
  end

  assign valid_o = active_q;
  assign last_o  = active_q & at_end;
  assign load_o  = start_ev | restart_ev;
  assign idx_o   = idx_q;

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && trig_i) |=> (valid_o && idx_o == '0));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o) && $stable(last_o)));
  // R9
  pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> valid_o);
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o && trig_i) |=> (valid_o && idx_o == '0));
  // R10
  idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o && !pend_q && !trig_i) |=> !valid_o);
endmodule

// File: rtl/status_frame_builder.sv
`timescale 1ns/1ps
module status_frame_builder
  import sfb_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int CH_W    = 12,
  parameter int TEMP_W  = 10,
  parameter int PAD_LEN = 47
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 query_i,
  input  logic                 reset_done_i,
  input  logic [7:0]           loc_i,
  input  logic [TEMP_W-1:0]    temp_i,
  input  logic [N_CH*CH_W-1:0] adc_i,
  output logic [7:0]           out_data_o,
  output logic                 out_valid_o,
  output logic                 out_last_o,
  input  logic                 out_ready_i
);
  localparam int IDX_W       = $clog2(PAD_LEN);
  localparam int PAYLOAD_LEN = 4 + 2 * N_CH;

  logic             trig, load;
  logic [IDX_W-1:0] beat_idx;
  logic [7:0]       h_loc;
  logic [TEMP_W-1:0] h_temp;
  logic [CH_W-1:0]  h_adc [N_CH];

  assign trig = query_i | reset_done_i;

  sfb_sequencer #(.PAD_LEN(PAD_LEN), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .last_o(out_last_o), .load_o(load), .idx_o(beat_idx)
  );

  sfb_hold #(.N_CH(N_CH), .CH_W(CH_W), .TEMP_W(TEMP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load), .loc_i(loc_i), .temp_i(temp_i),
    .adc_i(adc_i), .loc_o(h_loc), .temp_o(h_temp), .adc_o(h_adc)
  );

  sfb_byte_sel #(.N_CH(N_CH), .CH_W(CH_W), .TEMP_W(TEMP_W), .IDX_W(IDX_W)) u_sel (
    .loc_i(h_loc), .temp_i(h_temp), .adc_i(h_adc), .idx_i(beat_idx),
    .byte_o(out_data_o)
  );

  // R3
  type_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && beat_idx == IDX_W'(1)) |-> out_data_o == STATUS_TYPE);
  // R4
  temp_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && beat_idx == IDX_W'(2)) |-> (out_data_o >> (TEMP_W - 8)) == 8'h00);
  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && beat_idx >= IDX_W'(PAYLOAD_LEN)) |-> out_data_o == 8'h00);
  // R6
  last_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> (out_valid_o && out_data_o == 8'h00));
  // R7
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> $stable(out_data_o));
endmodule

// File: tb/status_frame_builder_bench.sv
`timescale 1ns/1ps
module status_frame_builder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, query, rdone, ready;
  logic [7:0]  loc;
  logic [9:0]  temp;
  logic [95:0] adc_flat;
  logic [7:0]  data;
  logic        valid, last;

  status_frame_builder u_status_frame_builder (
    .clk(clk), .rst_n(rst_n), .query_i(query), .reset_done_i(rdone),
    .loc_i(loc), .temp_i(temp), .adc_i(adc_flat),
    .out_data_o(data), .out_valid_o(valid), .out_last_o(last), .out_ready_i(ready)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  s_loc;
  logic [9:0]  s_temp;
  logic [11:0] s_adc [8];

  bit act_m = 0, pend_m = 0, stalled = 0, rep_bad = 0;
  int beat = 0, reports = 0;
  logic [7:0] held;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap_now();
    s_loc = loc;
    s_temp = temp;
    for (int c = 0; c < 8; c++) s_adc[c] = adc_flat[c*12 +: 12];
  endtask

  // Expected byte from the snapshot, computed with division and remainder.
  function automatic logic [7:0] exp_byte(input int i);
    int w;
    if (i == 0) return s_loc;
    if (i == 1) return 8'h53;
    if (i == 2) return 8'(s_temp / 256);
    if (i == 3) return 8'(s_temp % 256);
    if (i < 20) begin
      w = int'(s_adc[(i - 4) / 2]);
      return (i % 2 == 0) ? 8'(w / 256) : 8'(w % 256);
    end
    return 8'h00;
  endfunction

  task automatic jitter_inputs();
    loc = 8'($urandom);
    temp = 10'($urandom);
    for (int c = 0; c < 8; c++) adc_flat[c*12 +: 12] = 12'($urandom);
  endtask

  task automatic cycle(input bit tq, input bit tr, input bit rnd_rdy, input bit jit);
    bit trig, hs_last;
    string tag;
    @(negedge clk);
    if (jit) jitter_inputs();
    query = tq;
    rdone = tr;
    ready = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
    #1;
    trig = tq | tr;
    if (act_m) begin
      chk(valid === 1'b1, (beat == 0) ? "R2" : "R7", int'(valid), 1);
      if (stalled) chk(data === held, "R7", int'(data), int'(held));
      if (beat < 2) tag = "R3";
      else if (beat < 4) tag = "R4";
      else if (beat < 20) tag = "R5";
      else tag = "R6";
      chk(data === exp_byte(beat), tag, int'(data), int'(exp_byte(beat)));
      if (data !== exp_byte(beat)) rep_bad = 1;
      chk(last === (beat == 46), "R6", int'(last), int'(beat == 46));
      hs_last = ready && beat == 46;
      if (ready) begin
        stalled = 0;
        if (beat == 46) begin
          reports++;
          // R8: the whole report matched the snapshot taken at its start
          chk(!rep_bad, "R8", int'(rep_bad), 0);
          rep_bad = 0;
          if (pend_m || trig) begin
            snap_now();
            beat = 0;
            pend_m = 0;
          end else begin
            act_m = 0;
          end
        end else begin
          beat++;
        end
      end else begin
        stalled = 1;
        held = data;
      end
      if (trig && !hs_last) pend_m = 1;
    end else begin
      chk(valid === 1'b0, (reports == 0) ? "R1" : "R10", int'(valid), 0);
      if (trig) begin
        act_m = 1;
        beat = 0;
        rep_bad = 0;
        stalled = 0;
        snap_now();
      end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0;
    void'($urandom(32'd4711));
    rst_n = 0; query = 0; rdone = 0; ready = 1;
    loc = 0; temp = 0; adc_flat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) cycle(0, 0, 0, 0);                // R1 idle after reset

    // All-ones samples: upper bits of each word must read zero (R4, R5)
    @(negedge clk);
    loc = 8'hA5; temp = 10'h3FF; adc_flat = {96{1'b1}};
    cycle(1, 0, 0, 0);
    repeat (52) cycle(0, 0, 0, 0);

    // Distinct per-channel values, reset-done request, random stalls, input jitter (R7, R8)
    @(negedge clk);
    loc = 8'h3C; temp = 10'h201;
    for (int c = 0; c < 8; c++) adc_flat[c*12 +: 12] = 12'(c * 12'h111 + 12'h00F);
    cycle(0, 1, 0, 0);
    repeat (160) cycle(0, 0, 1, 1);

    // Burst of requests during a report: exactly one follow-on (R9)
    r0 = reports;
    cycle(1, 0, 0, 0);
    repeat (10) cycle(0, 0, 0, 0);
    cycle(1, 0, 0, 1);
    cycle(0, 0, 0, 1);
    cycle(0, 1, 0, 1);
    repeat (280) cycle(0, 0, 1, 1);
    chk(reports - r0 == 2, "R9", reports - r0, 2);

    // Request exactly on the final accepted byte: immediate restart (R9)
    r0 = reports;
    cycle(1, 0, 0, 1);
    repeat (46) cycle(0, 0, 0, 1);
    cycle(1, 0, 0, 1);
    repeat (60) cycle(0, 0, 0, 1);
    chk(reports - r0 == 2, "R9", reports - r0, 2);

    // Random request traffic
    repeat (3000) cycle($urandom % 40 == 0, $urandom % 60 == 0, 1, 1);
    repeat (200) cycle(0, 0, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule